// File: doc/BRIEF.md
# Edge-Interval Preburst Validator

This block decides whether a demodulated serial stream carries a real transmitter preamble or only noise. After a start pulse it measures the time between successive level changes of the stream, in clock cycles. Each measured interval must fall inside a programmable window. The window has a lower bound and an upper bound, each set by its own 5-bit limit word. A run of passing intervals of a selected length opens receive mode. In receive mode the stream is forwarded to the data output. A single interval outside the window ends the check and raises a sleep request.

The run length is chosen by a 2-bit select that gives a number of bits to verify. Each bit contributes two edge-to-edge intervals. The block latches its verdict, receive or sleep, until the next start pulse or reset. Demodulation and any wake-up scheduling are handled elsewhere.

Top module: `edgeWindowCheck`

## Requirements
- R1: `bitSel` values 0, 1, 2, 3 require 0, 3, 6 and 9 bits, that is 0, 6, 12 and 18 consecutive passing intervals. No earlier interval grants receive mode.
- R2: With `bitSel` = 0, `rxGrant` is high right after the clock edge that samples `startPulse`, without any data edge.
- R3: After a start, the first detected edge only arms the interval timer and is never judged. While the block waits for that edge, no time limit applies.
- R4: An interval is the number of clock cycles between two detected edges. It passes when `limMin` <= interval <= `limMax` - 1.
- R5: An interval shorter than `limMin` ends the check. `sleepAbort` rises at the clock edge that detects the closing edge.
- R6: Once the running interval reaches `limMax` cycles, the check ends without waiting for the next edge. The interval timer saturates and never wraps.
- R7: `rxGrant` rises at the same clock edge that detects the edge closing the last required interval. That is the third clock edge after the data input changes.
- R8: `dataIn` passes through a two-flop synchronizer. While `rxGrant` is high, `dataOut` follows `dataIn` two clock edges late. Otherwise `dataOut` is 0.
- R9: `rxGrant` and `sleepAbort` hold until a start pulse. A start pulse restarts the check from any state, and it takes priority over a grant or abort that falls in the same cycle.
- R10: After reset, `rxGrant`, `sleepAbort` and `dataOut` are low.
- R11: `rxGrant` and `sleepAbort` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one tick of interval timing |
| rstN | input | 1 | Asynchronous reset, active low |
| dataIn | input | 1 | Demodulated serial stream, asynchronous |
| startPulse | input | 1 | One-cycle request to begin a new check |
| limMin | input | 5 | Lower window bound in clock ticks |
| limMax | input | 5 | Upper window word; highest passing interval is limMax - 1 |
| bitSel | input | 2 | Number of bits to verify: 0, 3, 6 or 9 |
| rxGrant | output | 1 | Receive mode granted |
| sleepAbort | output | 1 | Check failed, request sleep |
| dataOut | output | 1 | Synchronized stream while granted, else 0 |

## Verification
The restart path and the verdict path can act in the same clock cycle. A start pulse can coincide with the edge that completes the final passing interval. It can also coincide with an abort. The bench times a start pulse so that it lands on the exact clock edge where the last required edge is detected. It then expects both flags to stay low, because the check has re-armed. The sweeps cover every bit-count select, several limit pairs, and interval lengths just inside and just outside each bound. Each sweep result is compared with the window rule worked out arithmetically in the bench.

// File: rtl/bitchk_pkg.sv
package bitchk_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARM,
    ST_MEAS,
    ST_RECV,
    ST_SLEEP
  } chkState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clear;    // new check: zero timer and pass count
    logic restart;  // edge accepted: timer restarts at one
    logic count;    // timer runs
    logic passInc;  // one more interval passed
  } ctrlStrb_t;

  // status from datapath to control
  typedef struct packed {
    logic edgeSeen;
    logic tooShort;
    logic tooLong;
    logic lastPass;
    logic needZero;
  } dpStat_t;

endpackage

// File: rtl/bitchk_datapath.sv
module bitchk_datapath
  import bitchk_pkg::*;
#(
  parameter int LIM_W         = 5,
  parameter int SEL_W         = 2,
  parameter int BIT_STEP      = 3,
  parameter int EDGES_PER_BIT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataIn,
  input  logic [LIM_W-1:0] limMin,
  input  logic [LIM_W-1:0] limMax,
  input  logic [SEL_W-1:0] bitSel,
  input  ctrlStrb_t        strb,
  output dpStat_t          stat,
  output logic             syncLevel
);

  localparam int CNT_W    = LIM_W + 1;
  localparam int MAX_NEED = ((1 << SEL_W) - 1) * BIT_STEP * EDGES_PER_BIT;
  localparam int PASS_W   = $clog2(MAX_NEED + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic syncA, syncB, syncC;
  logic edgeDet;
  logic [CNT_W-1:0]  intervalCnt;
  logic [PASS_W-1:0] passCnt;
  logic [PASS_W-1:0] passNext;
  logic [PASS_W-1:0] needCnt;

  // two-flop synchronizer plus one stage for edge detection
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= 1'b0;
      syncB <= 1'b0;
      syncC <= 1'b0;
    end else begin
      syncA <= dataIn;
      syncB <= syncA;
      syncC <= syncB;
    end
  end

  assign edgeDet   = syncB ^ syncC;
  assign syncLevel = syncB;

  // interval timer, saturating
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intervalCnt <= '0;
    end else if (strb.clear) begin
      intervalCnt <= '0;
    end else if (strb.restart) begin
      intervalCnt <= CNT_W'(1);
    end else if (strb.count && intervalCnt != CNT_MAX) begin
      intervalCnt <= intervalCnt + CNT_W'(1);
    end
  end

  // passed-interval counter
  assign passNext = passCnt + PASS_W'(1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      passCnt <= '0;
    end else if (strb.clear) begin
      passCnt <= '0;
    end else if (strb.passInc) begin
      passCnt <= passNext;
    end
  end

  assign needCnt = PASS_W'(bitSel) * PASS_W'(BIT_STEP * EDGES_PER_BIT);

  always_comb begin
    stat.edgeSeen = edgeDet;
    stat.tooShort = edgeDet && (intervalCnt < CNT_W'(limMin));
    stat.tooLong  = intervalCnt >= CNT_W'(limMax);
    stat.lastPass = passNext == needCnt;
    stat.needZero = needCnt == '0;
  end

  // R6
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intervalCnt == CNT_MAX && !strb.clear && !strb.restart) |=> intervalCnt == CNT_MAX);

  // R4
  cnt_restart_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.restart && !strb.clear) |=> intervalCnt == CNT_W'(1));

endmodule

// File: rtl/bitchk_control.sv
module bitchk_control
  import bitchk_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startPulse,
  input  dpStat_t   stat,
  output ctrlStrb_t strb,
  output logic      rxGrant,
  output logic      sleepAbort
);

  chkState_t st, stNext;

  always_comb begin
    strb   = '0;
    stNext = st;
    if (startPulse) begin
      strb.clear = 1'b1;
      stNext     = stat.needZero ? ST_RECV : ST_ARM;
    end else begin
      case (st)
        ST_ARM: begin
          if (stat.edgeSeen) begin
            strb.restart = 1'b1;
            stNext       = ST_MEAS;
          end
        end
        ST_MEAS: begin
          strb.count = 1'b1;
          if (stat.tooShort || stat.tooLong) begin
            stNext = ST_SLEEP;
          end else if (stat.edgeSeen) begin
            strb.restart = 1'b1;
            strb.passInc = 1'b1;
            if (stat.lastPass) stNext = ST_RECV;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) st <= ST_IDLE;
    else       st <= stNext;
  end

  assign rxGrant    = st == ST_RECV;
  assign sleepAbort = st == ST_SLEEP;

  // R11
  verdict_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(rxGrant && sleepAbort));

  // R9
  sleep_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sleepAbort && !startPulse) |=> sleepAbort);

  // R9
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxGrant && !startPulse) |=> rxGrant);

  // R9
  start_rearm_chk: assert property (@(posedge clk) disable iff (!rstN)
    (startPulse && !stat.needZero) |=> (!rxGrant && !sleepAbort));

  // R5
  abort_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepAbort) |-> $past(stat.tooShort || stat.tooLong));

  // R7
  grant_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rxGrant) |-> ($past(startPulse && stat.needZero) || $past(stat.edgeSeen && stat.lastPass)));

endmodule

// File: rtl/edgeWindowCheck.sv
module edgeWindowCheck
  import bitchk_pkg::*;
#(
  parameter int LIM_W         = 5,
  parameter int SEL_W         = 2,
  parameter int BIT_STEP      = 3,
  parameter int EDGES_PER_BIT = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataIn,
  input  logic             startPulse,
  input  logic [LIM_W-1:0] limMin,
  input  logic [LIM_W-1:0] limMax,
  input  logic [SEL_W-1:0] bitSel,
  output logic             rxGrant,
  output logic             sleepAbort,
  output logic             dataOut
);

  ctrlStrb_t strb;
  dpStat_t   stat;
  logic      syncLevel;

  bitchk_datapath #(
    .LIM_W(LIM_W), .SEL_W(SEL_W), .BIT_STEP(BIT_STEP), .EDGES_PER_BIT(EDGES_PER_BIT)
  ) uDp (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .limMin(limMin), .limMax(limMax),
    .bitSel(bitSel), .strb(strb), .stat(stat), .syncLevel(syncLevel)
  );

  bitchk_control uCtl (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .stat(stat), .strb(strb),
    .rxGrant(rxGrant), .sleepAbort(sleepAbort)
  );

  assign dataOut = rxGrant & syncLevel;

endmodule

// File: tb/sim_edgeWindowCheck.sv
module sim_edgeWindowCheck;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dataIn = 1'b0;
  logic startPulse = 1'b0;
  logic [4:0] limMin = 5'd2;
  logic [4:0] limMax = 5'd6;
  logic [1:0] bitSel = 2'd0;
  logic rxGrant, sleepAbort, dataOut;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  edgeWindowCheck u0 (
    .clk(clk), .rstN(rstN), .dataIn(dataIn), .startPulse(startPulse),
    .limMin(limMin), .limMax(limMax), .bitSel(bitSel),
    .rxGrant(rxGrant), .sleepAbort(sleepAbort), .dataOut(dataOut)
  );

  task automatic chk(input logic actual, input logic expected, input string tag);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s: actual %0b expected %0b at %0t", tag, actual, expected, $time);
    end
  endtask

  task automatic pulseStart();
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
  endtask

  task automatic setup(input int sel, input int lmin, input int lmax);
    bitSel = 2'(sel);
    limMin = 5'(lmin);
    limMax = 5'(lmax);
  endtask

  // one sweep point: constant interval t; all tasks start at a negedge
  task automatic runCase(input int sel, input int lmin, input int lmax, input int t);
    int need;
    bit pass;
    need = 6 * sel;
    pass = (t >= lmin) && (t <= lmax - 1);
    setup(sel, lmin, lmax);
    pulseStart();
    if (need == 0) begin
      chk(rxGrant, 1'b1, "R2 zero-bit grant");
      chk(sleepAbort, 1'b0, "R11 zero-bit");
      return;
    end
    repeat (2) @(negedge clk);
    for (int k = 0; k <= need; k++) begin
      dataIn = ~dataIn;
      if (k < need) repeat (t) @(negedge clk);
    end
    if (pass) begin
      repeat (2) @(negedge clk);
      chk(rxGrant, 1'b0, "R1 no early grant");
      @(negedge clk);
      chk(rxGrant, 1'b1, "R7/R4 grant on last edge");
      chk(sleepAbort, 1'b0, "R11 pass case");
    end else begin
      repeat (lmax + 6) @(negedge clk);
      chk(sleepAbort, 1'b1, (t < lmin) ? "R5 short abort" : "R6 long abort");
      chk(rxGrant, 1'b0, "R11 fail case");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int mins[2];
    int maxs[2];
    mins[0] = 2; mins[1] = 4;
    maxs[0] = 6; maxs[1] = 9;

    // R10 reset state
    dataIn = 1'b1;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk(rxGrant, 1'b0, "R10 grant low");
    chk(sleepAbort, 1'b0, "R10 sleep low");
    chk(dataOut, 1'b0, "R10 data low");

    // sweep over select, limits and interval lengths
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 2; a++)
        for (int b = 0; b < 2; b++)
          for (int ti = 0; ti < 4; ti++) begin
            int t;
            case (ti)
              0: t = mins[a] - 1;
              1: t = mins[a];
              2: t = maxs[b] - 1;
              default: t = maxs[b];
            endcase
            runCase(s, mins[a], maxs[b], t);
            repeat (3) @(negedge clk);
          end

    // R3: waiting for first edge has no time limit
    setup(1, 3, 8);
    pulseStart();
    repeat (40) @(negedge clk);
    chk(sleepAbort, 1'b0, "R3 no abort while unarmed");
    chk(rxGrant, 1'b0, "R3 no grant while unarmed");

    // R3: first edge right after start is not judged
    setup(1, 3, 8);
    pulseStart();
    dataIn = ~dataIn;
    for (int k = 0; k < 6; k++) begin
      repeat (5) @(negedge clk);
      dataIn = ~dataIn;
    end
    repeat (3) @(negedge clk);
    chk(rxGrant, 1'b1, "R3 first edge only arms");

    // R6: abort timing without closing edge, limMax = 7
    setup(1, 2, 7);
    pulseStart();
    repeat (2) @(negedge clk);
    dataIn = ~dataIn;
    repeat (2 + 7) @(negedge clk);
    chk(sleepAbort, 1'b0, "R6 not yet aborted");
    @(negedge clk);
    chk(sleepAbort, 1'b1, "R6 abort at limit");

    // R5: abort timing on a 1-cycle interval, limMin = 2
    setup(1, 2, 7);
    pulseStart();
    repeat (2) @(negedge clk);
    dataIn = ~dataIn;
    @(negedge clk);
    dataIn = ~dataIn;
    repeat (2) @(negedge clk);
    chk(sleepAbort, 1'b0, "R5 not yet aborted");
    @(negedge clk);
    chk(sleepAbort, 1'b1, "R5 abort on closing edge");

    // R9: start pulse on the clock of the final passing edge
    setup(1, 2, 9);
    pulseStart();
    repeat (2) @(negedge clk);
    for (int k = 0; k <= 6; k++) begin
      dataIn = ~dataIn;
      if (k < 6) repeat (4) @(negedge clk);
    end
    repeat (2) @(negedge clk);
    pulseStart();
    chk(rxGrant, 1'b0, "R9 start beats grant");
    chk(sleepAbort, 1'b0, "R9 start beats grant sleep");

    // R8: data forwarding while granted
    dataIn = 1'b0;
    setup(0, 2, 9);
    repeat (4) @(negedge clk);
    pulseStart();
    dataIn = 1'b1;
    @(negedge clk);
    chk(dataOut, 1'b0, "R8 one-cycle latency");
    @(negedge clk);
    chk(dataOut, 1'b1, "R8 two-cycle latency");
    dataIn = 1'b0;
    repeat (2) @(negedge clk);
    chk(dataOut, 1'b0, "R8 follows low");
    // R8 gated when not granted
    dataIn = 1'b1;
    setup(1, 2, 9);
    pulseStart();
    repeat (3) @(negedge clk);
    chk(dataOut, 1'b0, "R8 gated when not granted");

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule